// File: doc/BRIEF.md
# Round-Robin Trace Queue Drain Serializer

This block empties up to four capture queues onto one narrow serial trace port. When the shift register is idle and at least one queue reports a pending entry, the block takes exactly one entry. It starts looking at the queue after the one it last served and goes around the queues in ascending index order, passing over empty ones. It pulls the entry with a one-cycle pop strobe and loads it into the shift register. The frame then leaves the block most significant bits first, `LANE_W` bits per clock. A frame-start strobe marks the first beat of every frame.

Each entry carries a two-bit access size code, a header of `HDR_W` bits and a 64-bit payload. The used part of the payload sits in the low-order bits. Only the bytes named by the size code are sent, so short accesses take fewer beats. The queue storage and the assembly of entry fields happen upstream.

Top module: `trace_drain_serializer`

## Requirements
- R1: While `rst_n` is low no pop is issued. From the first clock edge in reset, `lanes` is zero and `frame_start` is low. The first queue examined after reset is queue 0.
- R2: At most one pop is asserted in any cycle. A pop goes only to a queue whose valid is high, and only while no frame is being shifted.
- R3: The queue granted is the first valid one found by scanning upward from the index after the last served queue, wrapping from NQ-1 to 0.
- R4: A queue that has just been served is not served again next time while any other queue is valid.
- R5: Empty queues cost no time. In any idle cycle with at least one valid queue, a pop is issued in that same cycle.
- R6: `frame_start` is high in the cycle right after a pop and only for that one cycle.
- R7: A frame occupies ceil((2 + HDR_W + P) / LANE_W) consecutive cycles. P is the payload bit count from the size code in entry bits [EW-1:EW-2]: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. The next pop can happen in the cycle after the last beat.
- R8: Bits leave MSB first in this order: the size code, then the header (entry bits [EW-3:64]), then payload bits P-1 down to 0. Zeros fill the last beat when needed. Within a beat, `lanes[LANE_W-1]` carries the earliest bit.
- R9: While no frame is being shifted, `lanes` is zero and `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | NQ | Queue i has an entry at its head |
| q_data | input | NQ*(66+HDR_W) | Head entries, queue i in slice i |
| q_pop | output | NQ | Queue i drops its head at this edge |
| lanes | output | LANE_W | Serial trace data, earliest bit in the MSB |
| frame_start | output | 1 | First beat of a frame |

## Verification
The pop depends combinationally on the valids and is due in the same cycle they are presented while the shifter is idle. `frame_start` and the first beat appear one cycle after the pop edge, and each later beat follows one cycle after the one before. The bench drives inputs at the falling edge and checks the pop 1 ns later, before the rising edge. It checks `lanes` and `frame_start` at the next falling edge against a bit-level model that advances exactly one beat per rising edge. Since the pop can only come in the cycle after the last beat, the frame length is checked by the pop check as well.

// File: rtl/trace_drain_pkg.sv
// Shared definitions for the trace drain serializer: payload size codes and
// frame length arithmetic. Assumes a 64-bit payload field in every entry.
package trace_drain_pkg;
    localparam int PAYLOAD_W = 64;
    localparam int SIZE_W    = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } access_size_e;

    // number of payload bits carried for a size code
    function automatic int payload_bits(access_size_e s);
        return 8 << int'(s);
    endfunction

    // number of port beats a frame needs for a size code
    function automatic int frame_beats(access_size_e s, int hdr_w, int lane_w);
        return (SIZE_W + hdr_w + payload_bits(s) + lane_w - 1) / lane_w;
    endfunction
endpackage

// File: rtl/rr_queue_picker.sv
// Rotating-priority picker. Scans requests starting at the pointer and
// grants the first one found. The pointer moves to the index after the granted
// queue only when the grant is taken. Assumes NQ >= 2.
module rr_queue_picker #(
    parameter int NQ = 4,
    localparam int IW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] req,
    input  logic          take,
    output logic          any,
    output logic [NQ-1:0] gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;

    // find first request at or after the pointer, wrapping
    always_comb begin
        int idx;
        any     = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < NQ; k++) begin
            idx = int'(ptr) + k;
            if (idx >= NQ) idx = idx - NQ;
            if (!any && req[idx]) begin
                any     = 1'b1;
                gnt_idx = IW'(idx);
            end
        end
        gnt = any ? (NQ'(1) << gnt_idx) : '0;
    end

    // pointer moves past the served queue only
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (take)
            ptr <= (int'(gnt_idx) == NQ - 1) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/frame_shifter.sv
// Loads one entry and shifts it out MSB first, LANE_W bits per clock.
// The frame is the size code, the header and the used payload bits, with zero
// fill in the last beat. Assumes load is only given while busy is low.
module frame_shifter
    import trace_drain_pkg::*;
#(
    parameter int HDR_W  = 22,
    parameter int LANE_W = 4,
    localparam int EW        = SIZE_W + HDR_W + PAYLOAD_W,
    localparam int BEATS_MAX = (EW + LANE_W - 1) / LANE_W,
    localparam int SH_W      = BEATS_MAX * LANE_W,
    localparam int CW        = $clog2(BEATS_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [EW-1:0]     entry,
    output logic [LANE_W-1:0] lanes,
    output logic              frame_start,
    output logic              busy
);
    logic [SH_W-1:0]      shreg;
    logic [SH_W-1:0]      image;
    logic [CW-1:0]        left;
    logic                 first;
    access_size_e         size;
    logic [PAYLOAD_W-1:0] aligned;

    // build the left-justified frame image of the incoming entry
    always_comb begin
        size    = access_size_e'(entry[EW-1 -: SIZE_W]);
        aligned = entry[PAYLOAD_W-1:0] << (PAYLOAD_W - payload_bits(size));
        image   = '0;
        image[SH_W-1 -: EW] = {entry[EW-1:PAYLOAD_W], aligned};
    end

    // load, shift and count beats of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            first <= 1'b0;
        end else if (load) begin
            shreg <= image;
            left  <= CW'(frame_beats(size, HDR_W, LANE_W));
            first <= 1'b1;
        end else if (left != '0) begin
            shreg <= (left == CW'(1)) ? '0 : (shreg << LANE_W);
            left  <= left - 1'b1;
            first <= 1'b0;
        end
    end

    assign busy        = (left != '0);
    assign lanes       = busy ? shreg[SH_W-1 -: LANE_W] : '0;
    assign frame_start = busy && first;
endmodule

// File: rtl/trace_drain_serializer.sv
// Top: drains NQ capture queues one entry per turn in rotating order into a
// single serial trace port. Queues must hold q_data stable while q_valid is
// high and drop the head on an edge where q_pop is high.
module trace_drain_serializer
    import trace_drain_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int HDR_W  = 22,
    parameter int LANE_W = 4,
    localparam int EW = SIZE_W + HDR_W + PAYLOAD_W,
    localparam int IW = $clog2(NQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NQ-1:0]      q_valid,
    input  logic [NQ*EW-1:0]   q_data,
    output logic [NQ-1:0]      q_pop,
    output logic [LANE_W-1:0]  lanes,
    output logic               frame_start
);
    logic          any_req;
    logic [NQ-1:0] gnt;
    logic [IW-1:0] gnt_idx;
    logic          shift_busy;
    logic          take;
    logic [EW-1:0] sel_entry;

    rr_queue_picker #(.NQ(NQ)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (q_valid),
        .take    (take),
        .any     (any_req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    // a grant is taken only when idle and out of reset
    assign take  = rst_n && !shift_busy && any_req;
    assign q_pop = take ? gnt : '0;

    // route the granted queue's head entry to the shifter
    always_comb begin
        sel_entry = '0;
        for (int i = 0; i < NQ; i++)
            if (gnt_idx == IW'(i)) sel_entry = q_data[i*EW +: EW];
    end

    frame_shifter #(.HDR_W(HDR_W), .LANE_W(LANE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (take),
        .entry       (sel_entry),
        .lanes       (lanes),
        .frame_start (frame_start),
        .busy        (shift_busy)
    );
endmodule

// File: rtl/trace_drain_checker.sv
// Protocol checks for trace_drain_serializer, attached by bind.
// Observes the queue handshake, the serial outputs and the shifter busy flag.
module trace_drain_checker #(
    parameter int NQ     = 4,
    parameter int LANE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NQ-1:0]     q_valid,
    input logic [NQ-1:0]     q_pop,
    input logic [LANE_W-1:0] lanes,
    input logic              frame_start,
    input logic              busy
);
    logic [NQ-1:0] last_pop;

    // remember which queue was served last
    always_ff @(posedge clk) begin
        if (!rst_n)          last_pop <= '0;
        else if (|q_pop)     last_pop <= q_pop;
    end

    // R1
    reset_no_pop_chk: assert property (@(posedge clk) !rst_n |-> q_pop == '0);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (lanes == '0 && !frame_start));
    // R2
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_pop));
    // R2
    pop_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |q_pop |-> (!busy && (q_pop & ~q_valid) == '0));
    // R4
    turn_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_pop && (q_valid & ~last_pop) != '0) |-> (q_pop & last_pop) == '0);
    // R5
    no_idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && |q_valid) |-> |q_pop);
    // R6
    start_follows_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |q_pop |=> frame_start);
    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lanes == '0 && !frame_start));
endmodule

bind trace_drain_serializer trace_drain_checker #(.NQ(NQ), .LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_valid     (q_valid),
    .q_pop       (q_pop),
    .lanes       (lanes),
    .frame_start (frame_start),
    .busy        (shift_busy)
);

// File: tb/tb_trace_drain_serializer.sv
// Bench: queue models feed the block with directed and random entries; a
// bit-level frame model predicts pops, beats and frame starts.
module tb_trace_drain_serializer;
    localparam int NQ = 4, HDR_W = 22, LANE_W = 4;
    localparam int EW = 2 + HDR_W + 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NQ-1:0]      q_valid = '0;
    logic [NQ*EW-1:0]   q_data = '0;
    logic [NQ-1:0]      q_pop;
    logic [LANE_W-1:0]  lanes;
    logic               frame_start;

    trace_drain_serializer #(.NQ(NQ), .HDR_W(HDR_W), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_data(q_data),
        .q_pop(q_pop), .lanes(lanes), .frame_start(frame_start));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [EW-1:0] bq [NQ][$];
    bit mq [$];
    bit mbusy = 0, mfirst = 0;
    int mptr = 0, last_srv = -1;

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [EW-1:0] rand_entry();
        logic [EW-1:0] e;
        e = {$urandom, $urandom, $urandom};
        return e;
    endfunction

    // frame bits per R8, zero filled to whole beats (R7)
    task automatic load_frame(logic [EW-1:0] e);
        int p;
        p = 8 << int'(e[EW-1:EW-2]);
        mq.delete();
        for (int i = EW - 1; i >= 64; i--) mq.push_back(e[i]);
        for (int i = p - 1; i >= 0; i--) mq.push_back(e[i]);
        while (mq.size() % LANE_W != 0) mq.push_back(1'b0);
    endtask

    function automatic logic [LANE_W-1:0] exp_lanes();
        logic [LANE_W-1:0] v = '0;
        if (mbusy)
            for (int i = 0; i < LANE_W; i++) v[LANE_W-1-i] = mq[i];
        return v;
    endfunction

    function automatic int exp_grant();
        if (!mbusy)
            for (int k = 0; k < NQ; k++)
                if (bq[(mptr + k) % NQ].size() != 0) return (mptr + k) % NQ;
        return -1;
    endfunction

    task automatic drive_inputs();
        for (int i = 0; i < NQ; i++) begin
            q_valid[i] = bq[i].size() != 0;
            q_data[i*EW +: EW] = (bq[i].size() != 0) ? bq[i][0] : rand_entry();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int g;
        bit other;
        void'($urandom(32'd20240917));
        // R1: valids high during reset must not pop
        q_valid = '1;
        repeat (3) begin
            @(negedge clk);
            check("R1 pop in reset", 64'(q_pop), 64'd0);
            check("R1 lanes in reset", 64'(lanes), 64'd0);
            check("R1 strobe in reset", 64'(frame_start), 64'd0);
        end
        q_valid = '0;
        rst_n = 1'b1;
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk);
            check(mbusy ? "R8 lanes" : "R9 lanes", 64'(lanes), 64'(exp_lanes()));
            check("R6 frame_start", 64'(frame_start), 64'(mbusy && mfirst));
            // directed cases, then random arrivals
            if (it == 0)
                for (int i = 0; i < NQ; i++) bq[i].push_back(rand_entry());
            else if (it == 200)
                for (int j = 0; j < 3; j++) bq[2].push_back(rand_entry());
            else if (it == 400)
                for (int j = 0; j < 2; j++) begin
                    bq[1].push_back(rand_entry());
                    bq[3].push_back(rand_entry());
                end
            else if (it >= 600 && it < 2900)
                for (int i = 0; i < NQ; i++)
                    if (bq[i].size() < 4 && ($urandom % 10) == 0) bq[i].push_back(rand_entry());
            drive_inputs();
            #1;
            g = exp_grant();
            check("R2 R3 R5 R7 pop", 64'(q_pop), (g < 0) ? 64'd0 : 64'(1) << g);
            if (g >= 0 && g == last_srv) begin
                other = 0;
                for (int i = 0; i < NQ; i++) if (i != g && bq[i].size() != 0) other = 1;
                if (other) begin n_fail++; $display("FAIL R4 queue %0d reserved, expected other", g); end
            end
            // model the rising edge
            if (mbusy) begin
                for (int i = 0; i < LANE_W; i++) void'(mq.pop_front());
                mfirst = 0;
                if (mq.size() == 0) mbusy = 0;
            end
            if (g >= 0) begin
                load_frame(bq[g].pop_front());
                mbusy = 1; mfirst = 1;
                mptr = (g + 1) % NQ;
                last_srv = g;
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule